// File: doc/BRIEF.md
# Receive-Fill Hysteresis Bus Arbiter

This block decides which of two DMA engines, the receive engine or the transmit engine, owns the system bus. It grants the bus to one engine at a time. Its decision depends on the request lines of both engines, on a control word, and on how full the receive FIFO is, given in eighths of its depth. When threshold arbitration is enabled and the receive FIFO has filled past an upper watermark, the receive engine gets strict priority. It keeps that priority until the fill has drained to a lower watermark. The hysteresis between the two watermarks stops the priority from toggling on every word. Otherwise the two engines share the bus round-robin.

A grant is registered and lasts while its holder keeps requesting. Three things end it early. The first is the beat limit: the granted engine reports each transferred word on `xfer_beat`, and the grant ends once the limit is reached. The second is preemption by a prioritised receive request. The third is the holder dropping its request. The block also decodes the control word into the largest burst length the engines may issue and the largest supported burst beat size. The DMA engines and the bus protocol live outside this block.

The package constant `ARB_CTRL_DEFAULT` holds the recommended setting: threshold arbitration enabled, upper watermark 6/8, lower watermark 2/8, unlimited burst.

Top module: `rxfill_bus_arbiter`

## Requirements
- R1: Control bit 9 enables threshold arbitration. While it is 0, receive priority is cleared at the next clock edge and stays cleared, whatever the fill level.
- R2: While enabled, receive priority becomes active at the clock edge after `fill_eighths` (0 to 8) is greater than or equal to the upper watermark in control bits 8:6.
- R3: Once active, receive priority holds while the fill stays above the lower watermark in control bits 5:3. It clears at the edge after the fill is at or below that watermark. If the two watermark tests disagree, the upper one wins.
- R4: With no receive priority, a free bus goes to the only requester. When both engines request, it goes to the engine that was not granted most recently. After reset, the first tie goes to the receive engine. At most one grant is high, and grants appear one cycle after the request.
- R5: While receive priority is active and the receive engine requests, the receive engine is granted at the next edge, and a transmit grant is withdrawn.
- R6: A grant stays with its holder while the holder keeps requesting. It is released at the edge after the request drops, and only a requesting engine is ever granted.
- R7: Control bits 15:14 give the burst limit on `burst_max`: code 0 means unlimited and reads 0, code 2 means 32 words, and code 3 means 64 words.
- R8: Burst code 1 is reserved. It reads as 0 on `burst_max` and behaves as unlimited.
- R9: With a limit in force, the grant is re-arbitrated at the edge of the limit-th `xfer_beat` counted while granted. The count starts again for the next grant.
- R10: `beat_len` reports the largest burst size flagged as supported: bit 2 gives 16, bit 1 gives 8, bit 0 gives 4. With no flag set it reports 1.
- R11: During reset, both grants are low and receive priority is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 16 | Control word (enable, watermarks, burst code, burst-size flags) |
| fill_eighths | input | 4 | Receive FIFO occupancy in eighths, 0 to 8 |
| rx_req | input | 1 | Receive DMA bus request |
| tx_req | input | 1 | Transmit DMA bus request |
| xfer_beat | input | 1 | One word transferred by the granted engine this cycle |
| grant_rx | output | 1 | Bus granted to the receive engine |
| grant_tx | output | 1 | Bus granted to the transmit engine |
| burst_max | output | 7 | Burst limit in words, 0 meaning unlimited |
| beat_len | output | 5 | Largest supported burst beat size |

## Verification
Two engines requesting together, with a 32-word limit and a beat every cycle, show whether the turn alternates and whether the limit lands on exactly the 32nd beat. A single requester holding an unlimited grant while the other engine raises its request separates holding from round-robin preemption. Stepping the fill through 5, 6, 4 and 2 while the receive request is toggled shows the priority state through the grant outputs: 6 must preempt, 4 must keep priority, and 2 must drop it. The same high fill with the enable bit cleared must have no effect. Every burst code and several flag combinations separate the reserved code from the real limits and the priority order of the size flags.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RX   = 2'd1,
    OWN_TX   = 2'd2
  } owner_e;

  localparam int CTRL_W     = 16;
  localparam int FILL_W     = 4;
  localparam int WM_W       = 3;
  localparam int BEAT_LEN_W = 5;

  // field positions decoded by this block
  localparam int POS_THR_EN = 9;
  localparam int POS_WM_HI  = 6;
  localparam int POS_WM_LO  = 3;
  localparam int POS_BURST  = 14;

  localparam logic [CTRL_W-1:0] ARB_CTRL_DEFAULT =
    CTRL_W'((1 << POS_THR_EN) | (6 << POS_WM_HI) | (2 << POS_WM_LO));

endpackage

// File: rtl/rx_fill_hyst.sv
module rx_fill_hyst #(
  parameter int FILL_W = 4,
  parameter int WM_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_en,
  input  logic [FILL_W-1:0] fill,
  input  logic [WM_W-1:0]   wm_hi,
  input  logic [WM_W-1:0]   wm_lo,
  output logic              prio
);

  localparam int PAD_W = FILL_W - WM_W;

  logic prio_q, prio_d;
  logic at_hi, at_lo;

  assign at_hi = fill >= {{PAD_W{1'b0}}, wm_hi};
  assign at_lo = fill <= {{PAD_W{1'b0}}, wm_lo};

  always_comb begin
    prio_d = prio_q;
    if (!thr_en)    prio_d = 1'b0;
    else if (at_hi) prio_d = 1'b1;
    else if (at_lo) prio_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= 1'b0;
    else        prio_q <= prio_d;
  end

  assign prio = prio_q;

endmodule

// File: rtl/burst_limit_dec.sv
module burst_limit_dec #(
  parameter int CAP_SHORT  = 32,
  parameter int CAP_LONG   = 64,
  parameter int CAP_W      = 7,
  parameter int BEAT_LEN_W = 5
) (
  input  logic [1:0]            code,
  input  logic [2:0]            size_flags,
  output logic [CAP_W-1:0]      cap_words,
  output logic [BEAT_LEN_W-1:0] beat_len
);

  always_comb begin
    case (code)
      2'd2:    cap_words = CAP_W'(CAP_SHORT);
      2'd3:    cap_words = CAP_W'(CAP_LONG);
      default: cap_words = '0;   // 0 and reserved 1: unlimited
    endcase
  end

  always_comb begin
    if (size_flags[2])      beat_len = BEAT_LEN_W'(16);
    else if (size_flags[1]) beat_len = BEAT_LEN_W'(8);
    else if (size_flags[0]) beat_len = BEAT_LEN_W'(4);
    else                    beat_len = BEAT_LEN_W'(1);
  end

endmodule

// File: rtl/grant_ctl.sv
module grant_ctl
  import arb_pkg::*;
#(
  parameter int CAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic             rx_prio,
  input  logic             xfer_beat,
  input  logic [CAP_W-1:0] cap_words,
  output logic             grant_rx,
  output logic             grant_tx,
  output logic             cap_hit
);

  owner_e           owner_q, owner_d;
  logic             last_rx_q, last_rx_d;
  logic [CAP_W-1:0] cnt_q, cnt_d;
  logic             cap_on, keep, cnt_en;

  assign cap_on  = |cap_words;
  assign cap_hit = cap_on && xfer_beat && (owner_q != OWN_NONE) &&
                   (cnt_q >= cap_words - CAP_W'(1));

  always_comb begin
    case (owner_q)
      OWN_RX:  keep = rx_req;
      OWN_TX:  keep = tx_req && !(rx_prio && rx_req);
      default: keep = 1'b0;
    endcase
    keep = keep && !cap_hit;
  end

  always_comb begin
    owner_d = owner_q;
    if (!keep) begin
      if (rx_prio && rx_req)    owner_d = OWN_RX;
      else if (rx_req && tx_req) owner_d = last_rx_q ? OWN_TX : OWN_RX;
      else if (rx_req)          owner_d = OWN_RX;
      else if (tx_req)          owner_d = OWN_TX;
      else                      owner_d = OWN_NONE;
    end
  end

  always_comb begin
    last_rx_d = last_rx_q;
    if (owner_d == OWN_RX)      last_rx_d = 1'b1;
    else if (owner_d == OWN_TX) last_rx_d = 1'b0;
  end

  assign cnt_en = !keep || (cap_on && xfer_beat);
  assign cnt_d  = keep ? cnt_q + CAP_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q   <= OWN_NONE;
      last_rx_q <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      last_rx_q <= last_rx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign grant_rx = (owner_q == OWN_RX);
  assign grant_tx = (owner_q == OWN_TX);

endmodule

// File: rtl/rxfill_bus_arbiter.sv
module rxfill_bus_arbiter
  import arb_pkg::*;
#(
  parameter int CAP_SHORT = 32,
  parameter int CAP_LONG  = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [15:0]                       ctrl,
  input  logic [3:0]                        fill_eighths,
  input  logic                              rx_req,
  input  logic                              tx_req,
  input  logic                              xfer_beat,
  output logic                              grant_rx,
  output logic                              grant_tx,
  output logic [$clog2(CAP_LONG+1)-1:0]     burst_max,
  output logic [4:0]                        beat_len
);

  localparam int CAP_W = $clog2(CAP_LONG + 1);

  logic            thr_en;
  logic [WM_W-1:0] wm_hi, wm_lo;
  logic [1:0]      burst_code;
  logic            rx_prio;
  logic            cap_hit;
  logic            unused_ctrl_bits;

  assign thr_en           = ctrl[POS_THR_EN];
  assign wm_hi            = ctrl[POS_WM_HI +: WM_W];
  assign wm_lo            = ctrl[POS_WM_LO +: WM_W];
  assign burst_code       = ctrl[POS_BURST +: 2];
  assign unused_ctrl_bits = ^ctrl[13:10];

  rx_fill_hyst #(.FILL_W(FILL_W), .WM_W(WM_W)) u_hyst (
    .clk    (clk),
    .rst_n  (rst_n),
    .thr_en (thr_en),
    .fill   (fill_eighths),
    .wm_hi  (wm_hi),
    .wm_lo  (wm_lo),
    .prio   (rx_prio)
  );

  burst_limit_dec #(
    .CAP_SHORT (CAP_SHORT),
    .CAP_LONG  (CAP_LONG),
    .CAP_W     (CAP_W),
    .BEAT_LEN_W(BEAT_LEN_W)
  ) u_dec (
    .code       (burst_code),
    .size_flags (ctrl[2:0]),
    .cap_words  (burst_max),
    .beat_len   (beat_len)
  );

  grant_ctl #(.CAP_W(CAP_W)) u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_req    (rx_req),
    .tx_req    (tx_req),
    .rx_prio   (rx_prio),
    .xfer_beat (xfer_beat),
    .cap_words (burst_max),
    .grant_rx  (grant_rx),
    .grant_tx  (grant_tx),
    .cap_hit   (cap_hit)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_req,
  input logic       tx_req,
  input logic       grant_rx,
  input logic       grant_tx,
  input logic       rx_prio,
  input logic       thr_en,
  input logic [3:0] fill,
  input logic [2:0] wm_hi,
  input logic [2:0] wm_lo,
  input logic       cap_hit
);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!grant_rx && !grant_tx && !rx_prio); // R11
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_rx && grant_tx)); // R4

  AST_RX_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_rx |-> $past(rx_req)); // R6

  AST_TX_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_tx |-> $past(tx_req)); // R6

  AST_PRIO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_en |=> !rx_prio); // R1

  AST_PRIO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_en && fill >= {1'b0, wm_hi}) |=> rx_prio); // R2

  AST_PRIO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_en && rx_prio && fill > {1'b0, wm_lo}) |=> rx_prio); // R3

  AST_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_prio && rx_req) |=> grant_rx); // R5

  AST_CAP_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit && grant_rx && tx_req && !rx_prio) |=> grant_tx); // R9

endmodule

bind rxfill_bus_arbiter arb_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_req   (rx_req),
  .tx_req   (tx_req),
  .grant_rx (grant_rx),
  .grant_tx (grant_tx),
  .rx_prio  (rx_prio),
  .thr_en   (thr_en),
  .fill     (fill_eighths),
  .wm_hi    (wm_hi),
  .wm_lo    (wm_lo),
  .cap_hit  (cap_hit)
);

// File: tb/tb_rxfill_bus_arbiter.sv
`timescale 1ns/1ps
module tb_rxfill_bus_arbiter;

  logic        clk;
  logic        rst_n;
  logic [15:0] ctrl;
  logic [3:0]  fill_eighths;
  logic        rx_req, tx_req, xfer_beat;
  logic        grant_rx, grant_tx;
  logic [6:0]  burst_max;
  logic [4:0]  beat_len;

  int checks;
  int failures;
  bit finished;

  // enable bit 9, upper 6 in bits 8:6, lower 2 in bits 5:3
  localparam logic [15:0] CFG_HYST = 16'h0390;

  rxfill_bus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .fill_eighths(fill_eighths),
    .rx_req(rx_req), .tx_req(tx_req), .xfer_beat(xfer_beat),
    .grant_rx(grant_rx), .grant_tx(grant_tx),
    .burst_max(burst_max), .beat_len(beat_len)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_idle();
    rx_req = 0; tx_req = 0; xfer_beat = 0;
    cycles(2);
  endtask

  task automatic t_reset();
    rst_n = 0; ctrl = 16'h0; fill_eighths = 0;
    rx_req = 1; tx_req = 1; xfer_beat = 0;
    cycles(3);
    chk("R11 grant_rx in reset", int'(grant_rx), 0);
    chk("R11 grant_tx in reset", int'(grant_tx), 0);
    rx_req = 0; tx_req = 0;
    rst_n = 1;
    cycles(2);
    chk("R11 grant_rx idle after reset", int'(grant_rx), 0);
    chk("R11 grant_tx idle after reset", int'(grant_tx), 0);
  endtask

  task automatic t_decode();
    for (int c = 0; c < 4; c++) begin
      int exp_cap;
      ctrl = 16'(c << 14);
      #0.5;
      exp_cap = (c == 2) ? 32 : (c == 3) ? 64 : 0;
      if (c == 1) chk("R8 reserved burst code", int'(burst_max), exp_cap);
      else        chk("R7 burst limit code", int'(burst_max), exp_cap);
    end
    for (int f = 0; f < 8; f++) begin
      int exp_len;
      ctrl = 16'(f);
      #0.5;
      exp_len = f[2] ? 16 : f[1] ? 8 : f[0] ? 4 : 1;
      chk("R10 beat size flags", int'(beat_len), exp_len);
    end
    ctrl = 16'h0;
    @(negedge clk);
  endtask

  // both engines request, 32-word limit, one beat per cycle
  task automatic t_round_robin_cap();
    ctrl = 16'(2 << 14);
    rx_req = 1; tx_req = 1; xfer_beat = 1;
    cycles(1);
    chk("R4 first tie goes to rx", int'(grant_rx), 1);
    chk("R4 single grant", int'(grant_tx), 0);
    cycles(31);
    chk("R9 rx held through beat 31", int'(grant_rx), 1);
    cycles(1);
    chk("R9 tx granted after 32nd beat", int'(grant_tx), 1);
    chk("R9 rx released after 32nd beat", int'(grant_rx), 0);
    cycles(31);
    chk("R9 tx held through its beat 31", int'(grant_tx), 1);
    cycles(1);
    chk("R4 turn returns to rx", int'(grant_rx), 1);
    go_idle();
    ctrl = 16'(1 << 14);
    rx_req = 1; xfer_beat = 1;
    cycles(1);
    tx_req = 1;
    cycles(80);
    chk("R8 reserved code never forces release", int'(grant_rx), 1);
    go_idle();
  endtask

  task automatic t_hold();
    ctrl = 16'h0;
    tx_req = 1; xfer_beat = 1;
    cycles(1);
    chk("R4 lone tx requester granted", int'(grant_tx), 1);
    cycles(80);
    chk("R6 tx held with unlimited burst", int'(grant_tx), 1);
    rx_req = 1;
    cycles(3);
    chk("R6 tx kept while rx waits", int'(grant_tx), 1);
    tx_req = 0;
    cycles(1);
    chk("R6 rx granted after tx drops", int'(grant_rx), 1);
    chk("R6 tx released after drop", int'(grant_tx), 0);
    go_idle();
  endtask

  task automatic t_hysteresis();
    ctrl = CFG_HYST; fill_eighths = 5;
    tx_req = 1;
    cycles(2);
    rx_req = 1;
    cycles(3);
    chk("R2 fill below upper gives no priority", int'(grant_tx), 1);
    fill_eighths = 6;
    cycles(1);
    chk("R2 priority registered one edge later", int'(grant_tx), 1);
    cycles(1);
    chk("R5 rx preempts at upper watermark", int'(grant_rx), 1);
    fill_eighths = 4; rx_req = 0;
    cycles(2);
    chk("R6 tx takes bus when rx idle", int'(grant_tx), 1);
    rx_req = 1;
    cycles(1);
    chk("R3 priority kept between watermarks", int'(grant_rx), 1);
    rx_req = 0; fill_eighths = 2;
    cycles(2);
    chk("R6 tx regains bus", int'(grant_tx), 1);
    rx_req = 1;
    cycles(3);
    chk("R3 priority dropped at lower watermark", int'(grant_tx), 1);
    go_idle();
  endtask

  task automatic t_disable();
    ctrl = CFG_HYST & ~16'h0200; fill_eighths = 8;
    tx_req = 1;
    cycles(2);
    rx_req = 1;
    cycles(3);
    chk("R1 full fifo ignored when disabled", int'(grant_tx), 1);
    chk("R1 rx not granted when disabled", int'(grant_rx), 0);
    go_idle();
  endtask

  initial begin
    checks = 0; failures = 0; finished = 0;
    t_reset();
    t_decode();
    t_round_robin_cap();
    t_hold();
    t_hysteresis();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule